// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device side of a parallel ATA task-file register set. A host addresses eight registers with a 3-bit offset on a simple register bus. Control registers are one byte wide, and the data register returns a full word. The block keeps the shadow copies of the sector count, the LBA bytes and the device register. It decodes each command byte, presents the status flags and drives one interrupt line.

Three command families are supported. IDENTIFY streams a fixed number of words through the data port. The words come from an external word source, which is addressed by the index the block presents. FLUSH CACHE keeps the device busy until an external completion pulse arrives. READ DMA and WRITE DMA raise a request toward a separate bus-master engine, which ends the transfer with a done pulse. When a command is accepted, the block latches the 28-bit LBA and the sector count and holds them for that engine.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status register reads 0x40 (bit 6 DRDY set; bit 7 BSY, bit 5 DF, bit 3 DRQ and bit 0 ERR clear), and `irq_o` and `dma_req_o` are low.
- R2: Offsets 2, 3, 4, 5 and 6 hold the sector count, the LBA low, mid and high bytes, and the device register. Each reads back what was written, in bits 7:0 of `reg_rdata_o`. Bit 4 of the device register (select device 1) always reads 0.
- R3: Writing 0xEC to offset 7 starts an identify stream and raises `irq_o`. For each of the ID_WORDS data reads at offset 0, status reads 0x48 beforehand. The data read returns `id_word_i` while `id_idx_o` counts 0, 1, 2 and so on.
- R4: After the last identify word is read, status reads 0x40. Later reads of offset 0 return 0.
- R5: After 0xE7 (FLUSH CACHE) is written, status reads 0xC0 until `flush_done_i` pulses. Status then reads 0x40 and `irq_o` is raised.
- R6: A read of offset 7 clears `irq_o` on the next cycle. If a completion event falls in the same cycle, the interrupt stays asserted.
- R7: 0xC8 (READ DMA) and 0xCA (WRITE DMA) assert `dma_req_o` and show status 0xC0. `dma_dir_o` is 1 for READ DMA (device to memory) and 0 for WRITE DMA. On `dma_done_i`, `dma_req_o` drops, status reads 0x40 and `irq_o` is raised.
- R8: Any other command code gives status 0x41 and raises `irq_o`. The next accepted command clears ERR.
- R9: On each accepted command write, `lba_o` latches {device[3:0], LBA high, LBA mid, LBA low} and `sector_count_o` latches the sector count. Both then hold until the next accepted command.
- R10: A sector count of 0 latches as 256 on `sector_count_o`.
- R11: A command write while BSY or DRQ is set is ignored: the status and the latched LBA and count do not change.
- R12: A `flush_done_i` or `dma_done_i` pulse with no matching command outstanding changes neither the status nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write byte |
| reg_rd_i | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_rdata_o | output | WORD_W | Read data for the addressed register, combinational |
| id_idx_o | output | IDX_W | Index of the identify word being presented |
| id_word_i | input | WORD_W | Identify word at `id_idx_o` |
| flush_done_i | input | 1 | Flush completion pulse |
| dma_done_i | input | 1 | DMA completion pulse from the bus-master engine |
| dma_req_o | output | 1 | DMA transfer requested |
| dma_dir_o | output | 1 | 1 = device to memory, 0 = memory to device |
| lba_o | output | 28 | Latched LBA |
| sector_count_o | output | 9 | Latched sector count, 1 to 256 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: ID_WORDS = 256 and WORD_W = 16. With these values a full identify stream fits in the run, so the last-word boundary and the return to idle are both reached. Randomized DMA commands use seeded LBA, count and device values, and the count-zero wrap to 256 is exercised directly. Directed cases cover a command written while busy, stray completion pulses, and a status read that falls in the same cycle as a completion.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_LBA_L = 3'd3;
  localparam logic [2:0] OFS_LBA_M = 3'd4;
  localparam logic [2:0] OFS_LBA_H = 3'd5;
  localparam logic [2:0] OFS_DEV   = 3'd6;
  localparam logic [2:0] OFS_STCMD = 3'd7;

  localparam int ST_BUSY  = 7;
  localparam int ST_READY = 6;
  localparam int ST_FAULT = 5;
  localparam int ST_XFER  = 3;
  localparam int ST_ERROR = 0;

  localparam logic [7:0] OP_RD_DMA = 8'hC8;
  localparam logic [7:0] OP_WR_DMA = 8'hCA;
  localparam logic [7:0] OP_FLUSH  = 8'hE7;
  localparam logic [7:0] OP_IDENT  = 8'hEC;

  localparam int LBA_W = 28;
  localparam int CNT_W = 9;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PIO   = 2'd1,
    PH_FLUSH = 2'd2,
    PH_DMA   = 2'd3
  } phase_e;
endpackage

// File: rtl/ata_tf_shadow.sv
module ata_tf_shadow
  import ata_tf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             latch_i,
  output logic [7:0]       rd_byte_o,
  output logic [LBA_W-1:0] lba_o,
  output logic [CNT_W-1:0] count_o
);
  logic [7:0] cnt_q, lo_q, mid_q, hi_q, dev_q;
  logic [LBA_W-1:0] lba_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; lo_q <= '0; mid_q <= '0; hi_q <= '0; dev_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        OFS_COUNT: cnt_q <= wdata_i;
        OFS_LBA_L: lo_q  <= wdata_i;
        OFS_LBA_M: mid_q <= wdata_i;
        OFS_LBA_H: hi_q  <= wdata_i;
        OFS_DEV:   dev_q <= {wdata_i[7:5], 1'b0, wdata_i[3:0]}; // only device 0 exists
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lba_q   <= '0;
      count_q <= CNT_W'(256);
    end else if (latch_i) begin
      lba_q   <= {dev_q[3:0], hi_q, mid_q, lo_q};
      count_q <= (cnt_q == 8'd0) ? CNT_W'(256) : CNT_W'(cnt_q);
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_COUNT: rd_byte_o = cnt_q;
      OFS_LBA_L: rd_byte_o = lo_q;
      OFS_LBA_M: rd_byte_o = mid_q;
      OFS_LBA_H: rd_byte_o = hi_q;
      OFS_DEV:   rd_byte_o = dev_q;
      default:   rd_byte_o = 8'h00;
    endcase
  end

  assign lba_o   = lba_q;
  assign count_o = count_q;

  assert_dev1_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_DEV) |-> !rd_byte_o[4]);
  assert_count_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) && (count_o <= CNT_W'(256)));
endmodule

// File: rtl/ata_tf_pio_cnt.sv
module ata_tf_pio_cnt #(
  parameter int ID_WORDS = 256,
  localparam int IDX_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (start_i)  idx_q <= '0;
    else if (step_i)   idx_q <= last_o ? '0 : idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_W'(ID_WORDS - 1));

  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_q) < ID_WORDS);
  assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i && !last_o) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic [7:0] cmd_i,
  input  logic       stat_rd_i,
  input  logic       data_rd_i,
  input  logic       pio_last_i,
  input  logic       flush_done_i,
  input  logic       dma_done_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       dma_req_o,
  output logic       dma_dir_o,
  output logic       accept_o,
  output logic       pio_start_o,
  output logic       pio_step_o
);
  phase_e phase_q, phase_d;
  logic   err_q, irq_q, dir_q;
  logic   idle, bad_op, irq_set;
  phase_e op_phase;

  assign idle     = (phase_q == PH_IDLE);
  assign accept_o = cmd_wr_i && idle;

  always_comb begin
    bad_op   = 1'b0;
    op_phase = PH_IDLE;
    unique case (cmd_i)
      OP_IDENT:             op_phase = PH_PIO;
      OP_FLUSH:             op_phase = PH_FLUSH;
      OP_RD_DMA, OP_WR_DMA: op_phase = PH_DMA;
      default:              bad_op   = 1'b1;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (accept_o) phase_d = op_phase;
      PH_PIO:   if (data_rd_i && pio_last_i) phase_d = PH_IDLE;
      PH_FLUSH: if (flush_done_i) phase_d = PH_IDLE;
      PH_DMA:   if (dma_done_i) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  // completion or data-ready events; a set wins over an acknowledge
  assign irq_set = (accept_o && (bad_op || op_phase == PH_PIO))
                || (phase_q == PH_FLUSH && flush_done_i)
                || (phase_q == PH_DMA && dma_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept_o) begin
        err_q <= bad_op;
        dir_q <= (cmd_i == OP_RD_DMA);
      end
      if (irq_set)        irq_q <= 1'b1;
      else if (stat_rd_i) irq_q <= 1'b0;
    end
  end

  always_comb begin
    status_o           = 8'h00;
    status_o[ST_BUSY]  = (phase_q == PH_FLUSH) || (phase_q == PH_DMA);
    status_o[ST_READY] = 1'b1;
    status_o[ST_FAULT] = 1'b0;
    status_o[ST_XFER]  = (phase_q == PH_PIO);
    status_o[ST_ERROR] = err_q;
  end

  assign irq_o       = irq_q;
  assign dma_req_o   = (phase_q == PH_DMA);
  assign dma_dir_o   = dir_q;
  assign pio_start_o = accept_o && (op_phase == PH_PIO);
  assign pio_step_o  = data_rd_i && (phase_q == PH_PIO);

  assert_flush_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FLUSH && !flush_done_i) |=> status_o[ST_BUSY]);
  assert_irq_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && idle && !cmd_wr_i) |=> !irq_o);
  assert_dma_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (status_o[ST_BUSY] && !status_o[ST_XFER]));
  assert_busy_cmd_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DMA && cmd_wr_i && !dma_done_i) |=> (dma_req_o && $stable(dma_dir_o)));
  assert_stray_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !cmd_wr_i && !irq_o) |=> (!irq_o && status_o[ST_READY] && !status_o[ST_BUSY]));
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_tf_pkg::*;
#(
  parameter int ID_WORDS = 256,
  parameter int WORD_W   = 16,
  localparam int IDX_W   = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [IDX_W-1:0]  id_idx_o,
  input  logic [WORD_W-1:0] id_word_i,
  input  logic              flush_done_i,
  input  logic              dma_done_i,
  output logic              dma_req_o,
  output logic              dma_dir_o,
  output logic [27:0]       lba_o,
  output logic [8:0]        sector_count_o,
  output logic              irq_o
);
  logic       cmd_wr, stat_rd, data_rd, accept, pio_start, pio_step, pio_last;
  logic [7:0] status, shadow_byte;

  assign cmd_wr  = reg_wr_i && (reg_addr_i == OFS_STCMD);
  assign stat_rd = reg_rd_i && (reg_addr_i == OFS_STCMD);
  assign data_rd = reg_rd_i && (reg_addr_i == OFS_DATA);

  ata_tf_shadow u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .latch_i   (accept),
    .rd_byte_o (shadow_byte),
    .lba_o     (lba_o),
    .count_o   (sector_count_o)
  );

  ata_tf_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (cmd_wr),
    .cmd_i        (reg_wdata_i),
    .stat_rd_i    (stat_rd),
    .data_rd_i    (data_rd),
    .pio_last_i   (pio_last),
    .flush_done_i (flush_done_i),
    .dma_done_i   (dma_done_i),
    .status_o     (status),
    .irq_o        (irq_o),
    .dma_req_o    (dma_req_o),
    .dma_dir_o    (dma_dir_o),
    .accept_o     (accept),
    .pio_start_o  (pio_start),
    .pio_step_o   (pio_step)
  );

  ata_tf_pio_cnt #(.ID_WORDS(ID_WORDS)) u_pio_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pio_start),
    .step_i  (pio_step),
    .idx_o   (id_idx_o),
    .last_o  (pio_last)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_DATA:  reg_rdata_o = status[ST_XFER] ? id_word_i : '0;
      OFS_STCMD: reg_rdata_o = WORD_W'(status);
      default:   reg_rdata_o = WORD_W'(shadow_byte);
    endcase
  end

  assert_latch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> ($stable(lba_o) && $stable(sector_count_o)));
  assert_data_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_addr_i == OFS_DATA) && !status[ST_XFER]) |-> (reg_rdata_o == '0));
endmodule

// File: tb/ata_taskfile_ctrl_tb.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl_tb;
  localparam int ID_WORDS = 256;
  localparam int WORD_W   = 16;
  localparam int IDX_W    = $clog2(ID_WORDS);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        reg_addr_i = '0;
  logic              reg_wr_i = 1'b0;
  logic [7:0]        reg_wdata_i = '0;
  logic              reg_rd_i = 1'b0;
  logic [WORD_W-1:0] reg_rdata_o;
  logic [IDX_W-1:0]  id_idx_o;
  logic [WORD_W-1:0] id_word_i;
  logic              flush_done_i = 1'b0;
  logic              dma_done_i = 1'b0;
  logic              dma_req_o, dma_dir_o, irq_o;
  logic [27:0]       lba_o;
  logic [8:0]        sector_count_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  function automatic logic [WORD_W-1:0] word_fn(input logic [IDX_W-1:0] i);
    return WORD_W'((32'(i) * 32'h9E37) ^ 32'h5A5A);
  endfunction

  assign id_word_i = word_fn(id_idx_o);

  ata_taskfile_ctrl #(.ID_WORDS(ID_WORDS), .WORD_W(WORD_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o),
    .id_idx_o(id_idx_o), .id_word_i(id_word_i), .flush_done_i(flush_done_i),
    .dma_done_i(dma_done_i), .dma_req_o(dma_req_o), .dma_dir_o(dma_dir_o),
    .lba_o(lba_o), .sector_count_o(sector_count_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [WORD_W-1:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #2 d = reg_rdata_o;
    @(posedge clk); #1;
    reg_rd_i = 1'b0;
  endtask

  task automatic pulse(input bit flush, input bit dma);
    @(negedge clk);
    flush_done_i = flush; dma_done_i = dma;
    @(posedge clk); #1;
    flush_done_i = 1'b0; dma_done_i = 1'b0;
  endtask

  task automatic load_tf(input logic [7:0] c, input logic [7:0] l, input logic [7:0] m,
                         input logic [7:0] h, input logic [7:0] dv);
    wr(3'd2, c); wr(3'd3, l); wr(3'd4, m); wr(3'd5, h); wr(3'd6, dv);
  endtask

  function automatic logic [8:0] cnt_exp(input logic [7:0] c);
    return (c == 8'd0) ? 9'd256 : {1'b0, c};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [WORD_W-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 dma_req", 32'(dma_req_o), 0);
    rd(3'd7, d); chk("R1 status", 32'(d), 32'h40);

    // R2 readback, device bit 4 masked
    load_tf(8'h12, 8'h34, 8'h56, 8'h78, 8'h5F);
    rd(3'd2, d); chk("R2 count", 32'(d), 32'h12);
    rd(3'd3, d); chk("R2 lba low", 32'(d), 32'h34);
    rd(3'd4, d); chk("R2 lba mid", 32'(d), 32'h56);
    rd(3'd5, d); chk("R2 lba high", 32'(d), 32'h78);
    rd(3'd6, d); chk("R2 device", 32'(d), 32'h4F);

    // R7 / R9 read DMA
    wr(3'd7, 8'hC8);
    chk("R9 lba", 32'(lba_o), 32'hF785634);
    chk("R9 count", 32'(sector_count_o), 32'h12);
    chk("R7 req", 32'(dma_req_o), 1);
    chk("R7 dir read", 32'(dma_dir_o), 1);
    rd(3'd7, d); chk("R7 busy status", 32'(d), 32'hC0);
    wr(3'd2, 8'h99);
    chk("R9 count held", 32'(sector_count_o), 32'h12);
    // R11 command while busy
    wr(3'd7, 8'hEC);
    rd(3'd7, d); chk("R11 status unchanged", 32'(d), 32'hC0);
    chk("R11 count unchanged", 32'(sector_count_o), 32'h12);
    chk("R11 req held", 32'(dma_req_o), 1);
    pulse(1'b0, 1'b1);
    chk("R7 irq on done", 32'(irq_o), 1);
    chk("R7 req dropped", 32'(dma_req_o), 0);
    rd(3'd7, d); chk("R7 done status", 32'(d), 32'h40);
    chk("R6 irq cleared", 32'(irq_o), 0);

    // R12 stray completions
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    chk("R12 no irq", 32'(irq_o), 0);
    rd(3'd7, d); chk("R12 status", 32'(d), 32'h40);

    // R10 count zero, write DMA direction
    wr(3'd2, 8'h00);
    wr(3'd7, 8'hCA);
    chk("R10 count 256", 32'(sector_count_o), 256);
    chk("R7 dir write", 32'(dma_dir_o), 0);
    pulse(1'b0, 1'b1);
    rd(3'd7, d);

    // R3 / R4 identify
    wr(3'd7, 8'hEC);
    chk("R3 irq on start", 32'(irq_o), 1);
    for (int i = 0; i < ID_WORDS; i++) begin
      logic [WORD_W-1:0] s, w;
      rd(3'd7, s);
      rd(3'd0, w);
      if (i == 0 || i == ID_WORDS - 1 || i % 37 == 0) begin
        chk("R3 status per word", 32'(s), 32'h48);
        chk("R3 word", 32'(w), 32'(word_fn(IDX_W'(i))));
      end else begin
        if (s !== 16'h48 || w !== word_fn(IDX_W'(i))) begin
          chk("R3 stream", {s, w}, {16'h48, word_fn(IDX_W'(i))});
        end
      end
    end
    chk("R3 irq acked", 32'(irq_o), 0);
    rd(3'd7, d); chk("R4 status after last", 32'(d), 32'h40);
    rd(3'd0, d); chk("R4 data idle zero", 32'(d), 0);

    // R5 flush
    wr(3'd7, 8'hE7);
    for (int k = 0; k < 3 + int'($urandom_range(0, 5)); k++) begin
      rd(3'd7, d); chk("R5 flush busy", 32'(d), 32'hC0);
    end
    chk("R5 no early irq", 32'(irq_o), 0);
    // R6 status read coinciding with completion: set wins
    @(negedge clk);
    reg_addr_i = 3'd7; reg_rd_i = 1'b1; flush_done_i = 1'b1;
    @(posedge clk); #1;
    reg_rd_i = 1'b0; flush_done_i = 1'b0;
    chk("R6 set wins", 32'(irq_o), 1);
    chk("R5 irq", 32'(irq_o), 1);
    rd(3'd7, d); chk("R5 done status", 32'(d), 32'h40);
    chk("R6 ack", 32'(irq_o), 0);

    // R8 unknown command
    wr(3'd7, 8'h00);
    chk("R8 irq", 32'(irq_o), 1);
    rd(3'd7, d); chk("R8 error status", 32'(d), 32'h41);
    wr(3'd7, 8'hC8);
    rd(3'd7, d); chk("R8 err cleared", 32'(d), 32'hC0);
    pulse(1'b0, 1'b1);
    rd(3'd7, d);

    // random DMA commands: R7 R9 R10
    for (int n = 0; n < 40; n++) begin
      logic [7:0] c, l, m, h, dv;
      logic rdir;
      c = 8'($urandom); l = 8'($urandom); m = 8'($urandom); h = 8'($urandom);
      dv = 8'($urandom);
      if (n % 8 == 0) c = 8'h00;
      rdir = 1'($urandom);
      load_tf(c, l, m, h, dv);
      wr(3'd7, rdir ? 8'hC8 : 8'hCA);
      chk("R9 rand lba", 32'(lba_o), 32'({dv[3:0], h, m, l}));
      chk("R10 rand count", 32'(sector_count_o), 32'(cnt_exp(c)));
      chk("R7 rand dir", 32'(dma_dir_o), 32'(rdir));
      repeat ($urandom_range(0, 4)) @(posedge clk);
      #1 pulse(1'b0, 1'b1);
      rd(3'd7, d); chk("R7 rand done", {16'(d), 15'd0, irq_o}, {16'h40, 15'd0, 1'b0});
    end

    finish_run();
  end
endmodule